// File: doc/BRIEF.md
# Compare and Branch Resolution Unit

This block keeps a five-bit condition register and uses it to resolve conditional branches. A compare strobe presents two 32-bit operands; on the next clock edge the condition register takes a new value that records whether the operands are equal or, if they differ, how they order as signed numbers and as unsigned numbers. Signed and unsigned results are kept in separate bits. When the operands are equal, only the equality bit is set.

A branch strobe presents a 16-bit branch instruction and the address of that instruction. One cycle later the block reports four things: whether the branch is taken, the sign-extended byte displacement, the next program counter, and whether the instruction is illegal. An illegal instruction has an undefined condition code or lacks the branch marker bits. Operands reach the block on its input ports. Register reads, instruction fetch and exception handling are done outside it.

Top module: `cond_branch_unit`

## Requirements
- R1: After reset the condition register `flags` is 5'b00000 and `res_valid` is low.
- R2: A compare of equal operands sets `flags` to 5'b00100, so bit 2 (equal) is the only bit set.
- R3: A compare of different operands sets exactly one of bit 1 (signed less) and bit 0 (signed greater), using a two's-complement comparison. It also sets exactly one of bit 4 (unsigned less) and bit 3 (unsigned greater), using an unsigned comparison. Bit 2 is cleared.
- R4: `flags` changes only on the clock edge that follows a cycle with `cmp_req` high. In every other cycle it holds its value.
- R5: A branch strobed in the same cycle as a compare is resolved against the flags that were held before that compare.
- R6: `res_valid` is high for exactly the one cycle after each `br_req` cycle. The result outputs change only on that edge.
- R7: `res_disp` is instruction bits 9:0 taken as a signed 10-bit number, shifted left by one and sign-extended to 32 bits. Its range is -1024 to +1022.
- R8: The condition code is instruction bits 13:10. The codes map as follows: 0 taken if bit2; 1 if not bit2; 2 if bit1; 3 if bit0; 4 if bit4; 5 if bit3; 6 if bit0 or bit2; 7 if bit1 or bit2; 8 if bit3 or bit2; 9 if bit4 or bit2.
- R9: For a legal branch, `res_next_pc` is the address plus 2 plus `res_disp` when the branch is taken, and the address plus 2 when it is not. The sum wraps modulo 2^32.
- R10: If the condition code is 10 to 15, or if instruction bits 15 and 14 are not both 1, then `res_illegal` is 1, `res_taken` is 0 and `res_next_pc` equals the instruction address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_req | input | 1 | Compare strobe |
| cmp_a | input | 32 | Left compare operand |
| cmp_b | input | 32 | Right compare operand |
| br_req | input | 1 | Branch strobe |
| br_insn | input | 16 | Branch instruction word |
| br_addr | input | 32 | Address of the branch instruction |
| flags | output | 5 | Condition register |
| res_valid | output | 1 | Branch result valid |
| res_taken | output | 1 | Branch taken |
| res_disp | output | 32 | Byte displacement |
| res_next_pc | output | 32 | Next program counter |
| res_illegal | output | 1 | Undefined condition or non-branch word |

## Verification
Both results are due exactly one edge after their strobe. New flags appear on the edge after `cmp_req`, and a branch result appears with `res_valid` on the edge after `br_req`, computed from the flags as they stood before that edge. The bench reference model advances on each rising edge using the inputs the bench drove in the previous half-cycle. Outputs are compared with the model at every falling edge, so every check samples the registers half a period after the edge that loaded them. Each of the six reachable flag patterns, including the all-zero reset value, is paired with all sixteen condition codes.

// File: rtl/cond_branch_unit.sv
`timescale 1ns/1ps
module cond_branch_unit #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int INSN_W = 16,
  parameter int OFF_W  = 10,
  parameter int CC_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_req,
  input  logic [DATA_W-1:0] cmp_a,
  input  logic [DATA_W-1:0] cmp_b,
  input  logic              br_req,
  input  logic [INSN_W-1:0] br_insn,
  input  logic [ADDR_W-1:0] br_addr,
  output logic [4:0]        flags,
  output logic              res_valid,
  output logic              res_taken,
  output logic [ADDR_W-1:0] res_disp,
  output logic [ADDR_W-1:0] res_next_pc,
  output logic              res_illegal
);
  localparam int          EXT_W    = ADDR_W - OFF_W - 1;
  localparam int          CC_LO    = OFF_W;
  localparam int          CC_HI    = OFF_W + CC_W - 1;
  localparam logic [CC_W-1:0] LAST_CC = CC_W'(9);

  // bit4 ult, bit3 ugt, bit2 eq, bit1 slt, bit0 sgt
  logic       op_eq, op_slt, op_ult;
  logic [4:0] flags_d;
  assign op_eq   = (cmp_a == cmp_b);
  assign op_slt  = ($signed(cmp_a) < $signed(cmp_b));
  assign op_ult  = (cmp_a < cmp_b);
  assign flags_d = op_eq ? 5'b00100 : {op_ult, ~op_ult, 1'b0, op_slt, ~op_slt};

  logic [CC_W-1:0]   cc;
  logic [OFF_W-1:0]  off;
  logic [ADDR_W-1:0] disp, seq_pc, next_pc;
  logic              marker_ok, illegal, cond_ok, taken;

  assign cc        = br_insn[CC_HI:CC_LO];
  assign off       = br_insn[OFF_W-1:0];
  assign marker_ok = &br_insn[INSN_W-1:INSN_W-2];
  assign disp      = {{EXT_W{off[OFF_W-1]}}, off, 1'b0};
  assign illegal   = !marker_ok || (cc > LAST_CC);
  assign taken     = !illegal && cond_ok;
  assign seq_pc    = br_addr + ADDR_W'(2);
  assign next_pc   = illegal ? br_addr : (taken ? seq_pc + disp : seq_pc);

  always_comb begin
    case (cc)
      4'd0:    cond_ok = flags[2];
      4'd1:    cond_ok = !flags[2];
      4'd2:    cond_ok = flags[1];
      4'd3:    cond_ok = flags[0];
      4'd4:    cond_ok = flags[4];
      4'd5:    cond_ok = flags[3];
      4'd6:    cond_ok = flags[0] | flags[2];
      4'd7:    cond_ok = flags[1] | flags[2];
      4'd8:    cond_ok = flags[3] | flags[2];
      4'd9:    cond_ok = flags[4] | flags[2];
      default: cond_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (cmp_req) begin
      flags <= flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_taken   <= 1'b0;
      res_disp    <= '0;
      res_next_pc <= '0;
      res_illegal <= 1'b0;
    end else begin
      res_valid <= br_req;
      if (br_req) begin
        res_taken   <= taken;
        res_disp    <= disp;
        res_next_pc <= next_pc;
        res_illegal <= illegal;
      end
    end
  end
endmodule

// File: rtl/cond_branch_unit_chk.sv
`timescale 1ns/1ps
module cond_branch_unit_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_req,
  input logic [DATA_W-1:0] cmp_a,
  input logic [DATA_W-1:0] cmp_b,
  input logic              br_req,
  input logic [ADDR_W-1:0] br_addr,
  input logic [4:0]        flags,
  input logic              res_valid,
  input logic              res_taken,
  input logic [ADDR_W-1:0] res_next_pc,
  input logic              res_illegal
);
  a_r2_eq_alone: assert property (@(posedge clk) disable iff (!rst_n)
    flags[2] |-> (flags == 5'b00100));

  a_r3_one_each: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags[2] && flags != 5'b0) |->
      ($countones(flags[1:0]) == 1 && $countones(flags[4:3]) == 1));

  a_r2_eq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_req |=> (flags[2] == ($past(cmp_a) == $past(cmp_b))));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_req |=> $stable(flags));

  a_r6_valid_on: assert property (@(posedge clk) disable iff (!rst_n)
    br_req |=> res_valid);

  a_r6_valid_off: assert property (@(posedge clk) disable iff (!rst_n)
    !br_req |=> !res_valid);

  a_r10_illegal_pc: assert property (@(posedge clk) disable iff (!rst_n)
    br_req |=> (!res_illegal || (!res_taken && res_next_pc == $past(br_addr))));

  a_r9_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    br_req |=> (res_illegal || res_taken ||
                res_next_pc == $past(br_addr) + ADDR_W'(2)));
endmodule

bind cond_branch_unit cond_branch_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_req(cmp_req), .cmp_a(cmp_a), .cmp_b(cmp_b),
  .br_req(br_req), .br_addr(br_addr), .flags(flags), .res_valid(res_valid),
  .res_taken(res_taken), .res_next_pc(res_next_pc), .res_illegal(res_illegal)
);

// File: tb/tb_cond_branch_unit.sv
`timescale 1ns/1ps
module tb_cond_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_req = 1'b0, br_req = 1'b0;
  logic [31:0] cmp_a = '0, cmp_b = '0, br_addr = '0;
  logic [15:0] br_insn = '0;
  logic [4:0]  flags;
  logic        res_valid, res_taken, res_illegal;
  logic [31:0] res_disp, res_next_pc;

  always #2.5 clk = ~clk;

  cond_branch_unit dut (
    .clk(clk), .rst_n(rst_n), .cmp_req(cmp_req), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .br_req(br_req), .br_insn(br_insn), .br_addr(br_addr), .flags(flags),
    .res_valid(res_valid), .res_taken(res_taken), .res_disp(res_disp),
    .res_next_pc(res_next_pc), .res_illegal(res_illegal)
  );

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  // reference model
  logic [4:0]  m_flags = '0;
  logic        m_valid = 0, m_taken = 0, m_ill = 0, m_same = 0;
  logic [31:0] m_disp = '0, m_npc = '0;
  string       m_ftag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flags = '0; m_valid = 0; m_ftag = "R1";
    end else begin
      m_valid = br_req;
      if (br_req) begin
        int cc, off;
        logic t;
        cc  = int'(br_insn[13:10]);
        off = int'(br_insn[9:0]);
        if (off >= 512) off = off - 1024;
        m_disp = 32'(off * 2);
        m_ill  = (br_insn[15:14] != 2'b11) || cc > 9;
        case (cc)
          0: t = m_flags[2];
          1: t = !m_flags[2];
          2: t = m_flags[1];
          3: t = m_flags[0];
          4: t = m_flags[4];
          5: t = m_flags[3];
          6: t = m_flags[0] || m_flags[2];
          7: t = m_flags[1] || m_flags[2];
          8: t = m_flags[3] || m_flags[2];
          9: t = m_flags[4] || m_flags[2];
          default: t = 0;
        endcase
        m_taken = !m_ill && t;
        m_npc   = m_ill ? br_addr : (m_taken ? br_addr + 32'd2 + m_disp : br_addr + 32'd2);
        m_same  = cmp_req;
      end
      if (cmp_req) begin
        if (cmp_a == cmp_b) begin
          m_flags = 5'b00100; m_ftag = "R2";
        end else begin
          int sa, sb;
          sa = int'(cmp_a); sb = int'(cmp_b);
          m_flags = 5'b0;
          if (sa < sb) m_flags[1] = 1; else m_flags[0] = 1;
          if (cmp_a < cmp_b) m_flags[4] = 1; else m_flags[3] = 1;
          m_ftag = "R3";
        end
      end else if (m_ftag != "R1") begin
        m_ftag = "R4";
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(m_ftag, flags, m_flags);
      chk("R6 valid", res_valid, m_valid);
      if (m_valid) begin
        chk("R7 disp", res_disp, m_disp);
        chk(m_same ? "R5 taken" : (m_ill ? "R10 taken" : "R8 taken"), res_taken, m_taken);
        chk(m_ill ? "R10 next pc" : "R9 next pc", res_next_pc, m_npc);
        chk("R10 illegal", res_illegal, m_ill);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<100000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic drive(input logic c, input logic [31:0] a, input logic [31:0] b,
                       input logic br, input logic [15:0] insn, input logic [31:0] addr);
    @(negedge clk); #1;
    cmp_req = c; cmp_a = a; cmp_b = b; br_req = br; br_insn = insn; br_addr = addr;
  endtask

  task automatic idle();
    drive(0, 32'h0, 32'h0, 0, 16'h0, 32'h0);
  endtask

  task automatic all_codes(input int seed);
    for (int cc = 0; cc < 16; cc++) begin
      logic [9:0] off;
      off = 10'((cc * 37 + seed * 101) % 1024);
      drive(0, 32'hDEAD, 32'hBEEF, 1, {2'b11, 4'(cc), off}, 32'h0000_1000 + 32'(seed * 64));
    end
    idle();
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flags reset", flags, 5'b0);
    chk("R1 valid reset", res_valid, 0);
    all_codes(0);
    drive(1, 32'd7, 32'd7, 0, 16'h0, 32'h0); idle(); all_codes(1);
    drive(1, 32'd3, 32'd9, 0, 16'h0, 32'h0); idle(); all_codes(2);
    drive(1, 32'd9, 32'd3, 0, 16'h0, 32'h0); idle(); all_codes(3);
    drive(1, 32'hFFFF_FFFF, 32'd1, 0, 16'h0, 32'h0); idle(); all_codes(4);
    drive(1, 32'd1, 32'hFFFF_FFFF, 0, 16'h0, 32'h0); idle(); all_codes(5);
    drive(1, 32'h8000_0000, 32'h7FFF_FFFF, 0, 16'h0, 32'h0); idle(); all_codes(6);
    // displacement extremes, eq flag set
    drive(1, 32'h55, 32'h55, 0, 16'h0, 32'h0);
    drive(0, 0, 0, 1, {2'b11, 4'd0, 10'h200}, 32'h0000_2000);
    drive(0, 0, 0, 1, {2'b11, 4'd0, 10'h1FF}, 32'h0000_2000);
    drive(0, 0, 0, 1, {2'b11, 4'd0, 10'h3FF}, 32'h0000_0000);
    drive(0, 0, 0, 1, {2'b11, 4'd0, 10'h001}, 32'hFFFF_FFFE);
    // non-branch marker
    drive(0, 0, 0, 1, {2'b01, 4'd0, 10'h010}, 32'h0000_3000);
    drive(0, 0, 0, 1, {2'b10, 4'd1, 10'h010}, 32'h0000_3000);
    // same-cycle compare and branch sees old flags (eq set; new compare clears it)
    drive(1, 32'd1, 32'd2, 1, {2'b11, 4'd0, 10'h020}, 32'h0000_4000);
    drive(1, 32'd5, 32'd5, 1, {2'b11, 4'd2, 10'h020}, 32'h0000_4000);
    drive(0, 0, 0, 1, {2'b11, 4'd2, 10'h020}, 32'h0000_4000);
    // back-to-back compares, flags hold through idles
    drive(1, 32'd2, 32'd1, 0, 16'h0, 32'h0);
    drive(1, 32'd1, 32'd2, 0, 16'h0, 32'h0);
    repeat (3) idle();
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule